// File: doc/BRIEF.md
# Quadrature Bus Clock Generator with Memory Slot Interleave

This block turns one master clock into the pair of quadrature bus clocks that pace a shared-memory system. The two clocks, E and Q, are a quarter cycle apart. Their four combined levels split every bus cycle into four phases, and the block also reports the current phase as a 2-bit index. Q leads E. Going round the cycle, the pair {E,Q} takes the values 00, 01, 11 and 10, then starts again.

The same phase counter decides who may use memory. In normal speed, the first half of each bus cycle (E low) is a video-fetch slot and the second half (E high) is a CPU slot. The video display generator does not take part in any arbitration: it simply receives its grant. When the fast speed is selected, the phases run twice as quickly and both slots go to the CPU, so video fetches stop. Nothing tells the video side about this. The video display generator gets its own clock, which runs freely and does not depend on the speed mode.

A new speed selection is only taken up at the edge that ends a bus cycle, so a cycle never has phases of mixed length.

Top module: `quad_clk_arbiter`

## Requirements
- R1: The phase index counts 0, 1, 2, 3, 0 and so on. Phase 0 drives {E,Q}=00, phase 1 drives 01, phase 2 drives 11 and phase 3 drives 10. E and Q never change on the same master edge.
- R2: In normal mode, each phase lasts NORM_DIV master cycles (4 by default), so a bus cycle lasts 16.
- R3: In fast mode, each phase lasts FAST_DIV master cycles (2 by default), so a bus cycle lasts 8.
- R4: In normal mode, vidGrant is high for exactly one master cycle, the first cycle of phase 1 (E low). cpuGrant is high for exactly one master cycle, the first cycle of phase 3 (E high). The two grants are never high together.
- R5: In fast mode, cpuGrant pulses for one master cycle at the start of phase 1 and again at the start of phase 3. vidGrant stays low.
- R6: speedSel (1 = fast) is sampled only on the master edge that moves the phase from 3 to 0. A change at any other time has no effect on the phase lengths or grants of the current bus cycle.
- R7: vidClk is a square wave whose level changes every VID_HALF master cycles (2 by default). Its timing does not depend on the speed mode.
- R8: While rst is high, the outputs are phase 0, E=0, Q=0, both grants low and vidClk low, and the mode is normal. After release, the first phase step comes after NORM_DIV master cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| speedSel | input | 1 | Requested speed mode (1 = fast) |
| eClk | output | 1 | Bus clock E |
| qClk | output | 1 | Bus clock Q, a quarter cycle ahead of E |
| phase | output | 2 | Current phase index 0..3 |
| cpuGrant | output | 1 | One-cycle CPU memory slot strobe |
| vidGrant | output | 1 | One-cycle video fetch slot strobe |
| vidClk | output | 1 | Clock for the video display generator |

## Verification
Every output is a register. A phase step, the E/Q levels and a grant strobe all appear on the master edge that completes the phase's divider count, so the phase index, E/Q and the grant strobe all change one edge after the divider reaches its limit. vidClk changes on every VID_HALF-th edge. The bench keeps a behavioural model that it advances on each rising edge from the same input values the design sees. It compares all outputs at the following falling edge, so each expected value is checked in the very cycle it is due. A speed change made in the middle of a cycle must therefore show up only after the next phase 3 ends. A run of phases with the old length after such a change is exactly what the model predicts.

// File: rtl/quad_clk_pkg.sv
package quad_clk_pkg;

  typedef logic [1:0] phase_t;

  localparam phase_t PH_START   = 2'd0;
  localparam phase_t PH_VIDSLOT = 2'd1;
  localparam phase_t PH_CPUSLOT = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic   stepEn;     // phase advances on this edge
    phase_t nextPhase;  // phase taken on the step
    logic   fastMode;   // mode of the bus cycle in progress
  } ctrl_t;

  // {E,Q} level pair for a phase index
  function automatic logic [1:0] phaseLevels(input phase_t p);
    case (p)
      2'd0:    phaseLevels = 2'b00;
      2'd1:    phaseLevels = 2'b01;
      2'd2:    phaseLevels = 2'b11;
      default: phaseLevels = 2'b10;
    endcase
  endfunction

endpackage

// File: rtl/quad_clk_ctrl.sv
module quad_clk_ctrl
  import quad_clk_pkg::*;
#(
  parameter int NORM_DIV = 4,
  parameter int FAST_DIV = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   speedSel,
  output phase_t phase,
  output ctrl_t  ctrl
);

  localparam int MAX_DIV = (NORM_DIV > FAST_DIV) ? NORM_DIV : FAST_DIV;
  localparam int DIV_W   = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;
  localparam logic [DIV_W-1:0] NORM_LAST = DIV_W'(NORM_DIV - 1);
  localparam logic [DIV_W-1:0] FAST_LAST = DIV_W'(FAST_DIV - 1);

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLast;
  logic             fastMode;
  logic             stepEn;
  logic             cycleEnd;
  phase_t           nextPhase;

  assign divLast   = fastMode ? FAST_LAST : NORM_LAST;
  assign stepEn    = (divCnt == divLast);
  assign nextPhase = phase + 2'd1;
  assign cycleEnd  = stepEn && (phase == PH_CPUSLOT);

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt   <= '0;
      phase    <= PH_START;
      fastMode <= 1'b0;
    end else begin
      if (stepEn) begin
        divCnt <= '0;
        phase  <= nextPhase;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
      if (cycleEnd) fastMode <= speedSel;
    end
  end

  assign ctrl = '{stepEn: stepEn, nextPhase: nextPhase, fastMode: fastMode};

  // R1: phase moves by exactly one on each step
  assert_phase_step_R1: assert property (@(posedge clk) disable iff (rst)
    stepEn |=> (phase == $past(phase) + 2'd1));

  // R1: phase holds between steps
  assert_phase_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !stepEn |=> (phase == $past(phase)));

  // R6: mode only changes on the edge leaving phase 3
  assert_mode_boundary_R6: assert property (@(posedge clk) disable iff (rst)
    (fastMode != $past(fastMode)) |-> ($past(phase) == PH_CPUSLOT && $past(stepEn)));

endmodule

// File: rtl/quad_clk_dp.sv
module quad_clk_dp
  import quad_clk_pkg::*;
#(
  parameter int VID_HALF = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  ctrl_t ctrl,
  output logic  eClk,
  output logic  qClk,
  output logic  cpuGrant,
  output logic  vidGrant,
  output logic  vidClk
);

  localparam int VID_W = (VID_HALF > 1) ? $clog2(VID_HALF) : 1;
  localparam logic [VID_W-1:0] VID_LAST = VID_W'(VID_HALF - 1);

  logic [VID_W-1:0] vidCnt;
  logic [1:0]       levelsNext;
  logic             vidSlotNext;
  logic             cpuSlotNext;

  assign levelsNext  = phaseLevels(ctrl.nextPhase);
  assign vidSlotNext = (ctrl.nextPhase == PH_VIDSLOT);
  assign cpuSlotNext = (ctrl.nextPhase == PH_CPUSLOT);

  // bus clocks and slot strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      eClk     <= 1'b0;
      qClk     <= 1'b0;
      cpuGrant <= 1'b0;
      vidGrant <= 1'b0;
    end else begin
      cpuGrant <= 1'b0;
      vidGrant <= 1'b0;
      if (ctrl.stepEn) begin
        {eClk, qClk} <= levelsNext;
        if (vidSlotNext) begin
          if (ctrl.fastMode) cpuGrant <= 1'b1;
          else               vidGrant <= 1'b1;
        end
        if (cpuSlotNext) cpuGrant <= 1'b1;
      end
    end
  end

  // free-running video clock
  always_ff @(posedge clk) begin
    if (rst) begin
      vidCnt <= '0;
      vidClk <= 1'b0;
    end else if (vidCnt == VID_LAST) begin
      vidCnt <= '0;
      vidClk <= ~vidClk;
    end else begin
      vidCnt <= vidCnt + 1'b1;
    end
  end

  // R1: quadrature, never both clocks moving on one edge
  assert_quadrature_R1: assert property (@(posedge clk) disable iff (rst)
    !((eClk != $past(eClk)) && (qClk != $past(qClk))));

  // R4: grants mutually exclusive
  assert_grant_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    !(cpuGrant && vidGrant));

  // R4: video slot only while E low and Q high
  assert_vid_slot_R4: assert property (@(posedge clk) disable iff (rst)
    vidGrant |-> (!eClk && qClk));

  // R5: fast mode starves video
  assert_fast_no_video_R5: assert property (@(posedge clk) disable iff (rst)
    ctrl.fastMode |-> !vidGrant);

  // R7: video clock edge only when its counter wraps
  assert_vidclk_period_R7: assert property (@(posedge clk) disable iff (rst)
    (vidClk != $past(vidClk)) |-> ($past(vidCnt) == VID_LAST));

endmodule

// File: rtl/quad_clk_arbiter.sv
module quad_clk_arbiter
  import quad_clk_pkg::*;
#(
  parameter int NORM_DIV = 4,
  parameter int FAST_DIV = 2,
  parameter int VID_HALF = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       speedSel,
  output logic       eClk,
  output logic       qClk,
  output logic [1:0] phase,
  output logic       cpuGrant,
  output logic       vidGrant,
  output logic       vidClk
);

  ctrl_t ctrl;

  quad_clk_ctrl #(.NORM_DIV(NORM_DIV), .FAST_DIV(FAST_DIV)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .speedSel (speedSel),
    .phase    (phase),
    .ctrl     (ctrl)
  );

  quad_clk_dp #(.VID_HALF(VID_HALF)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .eClk     (eClk),
    .qClk     (qClk),
    .cpuGrant (cpuGrant),
    .vidGrant (vidGrant),
    .vidClk   (vidClk)
  );

endmodule

// File: tb/quad_clk_arbiter_tb.sv
module quad_clk_arbiter_tb_top;

  localparam int NORM_DIV = 4;
  localparam int FAST_DIV = 2;
  localparam int VID_HALF = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       speedSel = 1'b0;
  logic       eClk, qClk, cpuGrant, vidGrant, vidClk;
  logic [1:0] phase;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  quad_clk_arbiter #(.NORM_DIV(NORM_DIV), .FAST_DIV(FAST_DIV), .VID_HALF(VID_HALF)) dut_i (
    .clk(clk), .rst(rst), .speedSel(speedSel),
    .eClk(eClk), .qClk(qClk), .phase(phase),
    .cpuGrant(cpuGrant), .vidGrant(vidGrant), .vidClk(vidClk)
  );

  // behavioural reference model
  int mPhase = 0, mTick = 0, mVidTick = 0;
  bit mFast = 0, mCpu = 0, mVid = 0, mVclk = 0;
  bit midCycleToggle = 0;  // set while a speed change is pending mid-cycle

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      mPhase = 0; mTick = 0; mVidTick = 0;
      mFast = 0; mCpu = 0; mVid = 0; mVclk = 0;
    end else begin
      mVidTick++;
      if (mVidTick == VID_HALF) begin mVidTick = 0; mVclk = !mVclk; end
      mCpu = 0; mVid = 0;
      mTick++;
      if (mTick == (mFast ? FAST_DIV : NORM_DIV)) begin
        mTick = 0;
        if (mPhase == 3) begin mFast = speedSel; midCycleToggle = 0; end
        mPhase = (mPhase + 1) % 4;
        if (mPhase == 1) begin if (mFast) mCpu = 1; else mVid = 1; end
        if (mPhase == 3) mCpu = 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cycles);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      int expEQ;
      string reqPh, reqG;
      expEQ = (mPhase == 0) ? 0 : (mPhase == 1) ? 1 : (mPhase == 2) ? 3 : 2;
      if (rst) begin reqPh = "R8"; reqG = "R8"; end
      else if (midCycleToggle) begin reqPh = "R6"; reqG = "R6"; end
      else begin reqPh = mFast ? "R3" : "R2"; reqG = mFast ? "R5" : "R4"; end
      check(phase == 2'(mPhase), reqPh, "phase", phase, mPhase);
      check({eClk, qClk} == 2'(expEQ), rst ? "R8" : "R1", "{E,Q}", {eClk, qClk}, expEQ);
      check(cpuGrant == mCpu, reqG, "cpuGrant", cpuGrant, mCpu);
      check(vidGrant == mVid, reqG, "vidGrant", vidGrant, mVid);
      check(vidClk == mVclk, rst ? "R8" : "R7", "vidClk", vidClk, mVclk);
    end
  end

  task automatic runCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // change speed in the middle of a bus cycle (phase 1)
  task automatic midCycleSet(input bit val);
    while (!(phase == 2'd1)) @(negedge clk);
    speedSel = val;
    midCycleToggle = 1;
  endtask

  initial begin
    runCycles(5);                      // R8 reset state
    rst = 1'b0;
    runCycles(3);
    check(phase == 2'd0, "R8", "phase before first step", phase, 0);
    runCycles(1);
    check(phase == 2'd1 && vidGrant, "R8", "first step after NORM_DIV", phase, 1);
    runCycles(100);                    // R2 R4 normal
    midCycleSet(1'b1);                 // R6 then R3 R5
    runCycles(120);
    midCycleSet(1'b0);                 // back to normal, R6
    runCycles(120);
    for (int i = 0; i < 400; i++) begin   // random toggling, R6
      speedSel = 1'($urandom_range(0, 1));
      runCycles(1 + $urandom_range(0, 6));
    end
    rst = 1'b1;                        // R8 mid-run reset
    speedSel = 1'b1;
    runCycles(4);
    rst = 1'b0;
    runCycles(200);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : watchdog
    #(4 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule